// File: doc/BRIEF.md
# Pixel Row Steering Sequencer

This block drives the row-control lines of a pixel sensor matrix. Each row has two control lines: a gate-select line that switches the row's transistors on and a clear line that empties the collected charge. A pass starts when a token arrives at a chip that is enabled. The block then walks through its channels in ascending order, either one row per step or two adjacent rows per step. Within each step it runs a fixed pattern. It selects the row, holds it for a settle time, and strobes the readout for a first sample, which is pedestal plus signal. It then pulses the clear line, strobes the readout for a second sample, which is pedestal only, and moves to the next row.

The four phase lengths are cycle counts supplied on input buses, so the timing inside a step is programmable and not wired in. After the last channel finishes, the chip hands a one-cycle token to the next chip in a cascade and goes idle with every output off. Because of this, exactly one row, or one row pair, is selected across the whole chain at any time. High-voltage level shifting and the analog sampling itself are handled outside this block.

Top module: `row_steer_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) deasserts every gate, clear, strobe and token output by the next cycle and returns the block to idle, so the next pass starts again at channel 0.
- R2: In idle, `token_in` high with `run` high at a clock edge starts a pass. In the cycle after that edge, `gate_en` equals 1 (channel 0) in single-row mode or 3 (channels 0 and 1) in double-row mode. A token seen while `run` is low leaves all outputs off.
- R3: Each step runs four phases in a fixed order, and the gate of the selected row(s) stays on throughout: settle for `t_settle` cycles, then `samp1_stb` high for `t_samp1` cycles, then the clear line high for `t_clear` cycles, then `samp2_stb` high for `t_samp2` cycles.
- R4: A phase length programmed as 0 lasts one cycle, the same as a length of 1.
- R5: At most the selected row, or row pair, has its gate on. Every other channel's gate stays off.
- R6: A channel's clear is on only while that channel's gate is on. The cycle after any clear cycle still selects the same row(s), because a clear never overlaps a row change.
- R7: In single-row mode the pass covers channels 0 to N_CH-1 in ascending order, one per step, with no idle cycle between steps. The gate is therefore on for N_CH × (step length) cycles.
- R8: In double-row mode step s drives gate and clear on both channels 2s and 2s+1, and a pass takes N_CH/2 steps.
- R9: After the last step's second sample, `token_out` is high for exactly one cycle with all gates, clears and strobes off. The block is idle in the cycle after that.
- R10: The row mode (`dbl_mode`: 0 single, 1 double) is captured when a pass starts. Changes during the pass have no effect on it.
- R11: `token_in` pulses that arrive while a pass or the token-out cycle is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enables the acceptance of an incoming token |
| dbl_mode | input | 1 | 0: single-row steps, 1: double-row steps (captured at pass start) |
| token_in | input | 1 | Start token from the previous chip, or from the controller |
| t_settle | input | CNT_W | Gate settle length in cycles (0 treated as 1) |
| t_samp1 | input | CNT_W | First sample strobe length in cycles |
| t_clear | input | CNT_W | Clear pulse length in cycles |
| t_samp2 | input | CNT_W | Second sample strobe length in cycles |
| gate_en | output | N_CH | Per-channel gate-select enables |
| clear_en | output | N_CH | Per-channel clear enables |
| samp1_stb | output | 1 | Readout strobe for the signal-plus-pedestal sample |
| samp2_stb | output | 1 | Readout strobe for the pedestal-only sample |
| token_out | output | 1 | One-cycle token to the next chip at the end of a pass |

## Verification
The outputs are decoded directly from registered state. A token sampled at an edge therefore shows up as the first gate in the cycle that edge opens. Each phase boundary shows up one edge after the last cycle of the previous phase, and the token out appears one edge after the final second-sample cycle. The bench drives inputs on the falling edge and updates a behavioural model of phases, counts and steps on the rising edge. It then compares every output vector against that model on the following falling edge, so each result is checked in the very cycle it is due. On top of that, each pass counts its gate-on cycles against the expected product of steps and step length. Directed checks cover a reset in the middle of a pass, a token sent while disabled, and tokens or mode flips that arrive while a pass is in progress.

// File: rtl/row_steer_pkg.sv
package row_steer_pkg;

   // Sequencer state: idle, the four in-row phases, and the hand-off cycle.
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETTLE = 3'd1,
      ST_SAMP1  = 3'd2,
      ST_CLEAR  = 3'd3,
      ST_SAMP2  = 3'd4,
      ST_HAND   = 3'd5
   } seq_state_e;

   function automatic logic is_row_phase(input seq_state_e s);
      return (s == ST_SETTLE) || (s == ST_SAMP1) ||
             (s == ST_CLEAR)  || (s == ST_SAMP2);
   endfunction

endpackage

// File: rtl/rsq_phase_timer.sv
module rsq_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic [CNT_W-1:0] dur,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   // A zero length is stretched to a single cycle.
   always_comb begin
      if (dur == '0) limit = '0;
      else           limit = dur - 1'b1;
   end

   assign last = (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (rst || restart) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/rsq_step_ctrl.sv
module rsq_step_ctrl
   import row_steer_pkg::*;
#(
   parameter int N_CH    = 64,
   parameter bit PAIR_EN = 1'b1,
   localparam int STEP_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   input  logic              token_in,
   input  logic              dbl_mode,
   input  logic              timer_last,
   output seq_state_e        state,
   output logic [STEP_W-1:0] step,
   output logic              dbl,
   output logic              timer_restart
);

   localparam logic [STEP_W-1:0] LAST_SINGLE = STEP_W'(N_CH - 1);
   localparam logic [STEP_W-1:0] LAST_DOUBLE = STEP_W'(N_CH / 2 - 1);

   seq_state_e        state_q, state_d;
   logic [STEP_W-1:0] step_q, step_d;
   logic              dbl_q, dbl_d;
   logic [STEP_W-1:0] last_step;

   assign last_step = dbl_q ? LAST_DOUBLE : LAST_SINGLE;

   always_comb begin
      state_d = state_q;
      step_d  = step_q;
      dbl_d   = dbl_q;
      unique case (state_q)
         ST_IDLE: begin
            if (token_in && run) begin
               state_d = ST_SETTLE;
               step_d  = '0;
               dbl_d   = PAIR_EN & dbl_mode;
            end
         end
         ST_SETTLE: if (timer_last) state_d = ST_SAMP1;
         ST_SAMP1:  if (timer_last) state_d = ST_CLEAR;
         ST_CLEAR:  if (timer_last) state_d = ST_SAMP2;
         ST_SAMP2: begin
            if (timer_last) begin
               if (step_q == last_step) begin
                  state_d = ST_HAND;
               end else begin
                  state_d = ST_SETTLE;
                  step_d  = step_q + 1'b1;
               end
            end
         end
         ST_HAND: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         dbl_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
         dbl_q   <= dbl_d;
      end
   end

   assign state         = state_q;
   assign step          = step_q;
   assign dbl           = dbl_q;
   assign timer_restart = !is_row_phase(state_q) || timer_last;

endmodule

// File: rtl/rsq_row_decoder.sv
module rsq_row_decoder #(
   parameter int N_CH    = 64,
   parameter bit PAIR_EN = 1'b1,
   localparam int STEP_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic              active,
   input  logic              clr_phase,
   input  logic              dbl,
   input  logic [STEP_W-1:0] step,
   output logic [N_CH-1:0]   gate_en,
   output logic [N_CH-1:0]   clear_en
);

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      localparam logic [STEP_W-1:0] SELF = STEP_W'(ch);
      localparam logic [STEP_W-1:0] PAIR = STEP_W'(ch / 2);
      logic hit;
      if (PAIR_EN) begin : g_pair
         assign hit = dbl ? (step == PAIR) : (step == SELF);
      end else begin : g_single
         assign hit = (step == SELF);
      end
      assign gate_en[ch]  = active && hit;
      assign clear_en[ch] = active && hit && clr_phase;
   end

endmodule

// File: rtl/row_steer_seq.sv
module row_steer_seq
   import row_steer_pkg::*;
#(
   parameter int N_CH    = 64,
   parameter int CNT_W   = 8,
   parameter bit PAIR_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic             dbl_mode,
   input  logic             token_in,
   input  logic [CNT_W-1:0] t_settle,
   input  logic [CNT_W-1:0] t_samp1,
   input  logic [CNT_W-1:0] t_clear,
   input  logic [CNT_W-1:0] t_samp2,
   output logic [N_CH-1:0]  gate_en,
   output logic [N_CH-1:0]  clear_en,
   output logic             samp1_stb,
   output logic             samp2_stb,
   output logic             token_out
);

   localparam int STEP_W = (N_CH > 1) ? $clog2(N_CH) : 1;

   if (N_CH < 2 || (N_CH % 2) != 0) begin : g_bad_nch
      $error("row_steer_seq: N_CH must be even and at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("row_steer_seq: CNT_W must be at least 1");
   end

   seq_state_e        state;
   logic [STEP_W-1:0] step;
   logic              dbl;
   logic              timer_last;
   logic              timer_restart;
   logic [CNT_W-1:0]  cur_dur;

   always_comb begin
      unique case (state)
         ST_SETTLE: cur_dur = t_settle;
         ST_SAMP1:  cur_dur = t_samp1;
         ST_CLEAR:  cur_dur = t_clear;
         ST_SAMP2:  cur_dur = t_samp2;
         default:   cur_dur = '0;
      endcase
   end

   rsq_step_ctrl #(.N_CH(N_CH), .PAIR_EN(PAIR_EN)) u_ctrl (
      .clk           (clk),
      .rst           (rst),
      .run           (run),
      .token_in      (token_in),
      .dbl_mode      (dbl_mode),
      .timer_last    (timer_last),
      .state         (state),
      .step          (step),
      .dbl           (dbl),
      .timer_restart (timer_restart)
   );

   rsq_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .restart (timer_restart),
      .dur     (cur_dur),
      .last    (timer_last)
   );

   rsq_row_decoder #(.N_CH(N_CH), .PAIR_EN(PAIR_EN)) u_dec (
      .active    (is_row_phase(state)),
      .clr_phase (state == ST_CLEAR),
      .dbl       (dbl),
      .step      (step),
      .gate_en   (gate_en),
      .clear_en  (clear_en)
   );

   assign samp1_stb = (state == ST_SAMP1);
   assign samp2_stb = (state == ST_SAMP2);
   assign token_out = (state == ST_HAND);

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
   parameter int N_CH = 64
) (
   input logic            clk,
   input logic            rst,
   input logic [N_CH-1:0] gate_en,
   input logic [N_CH-1:0] clear_en,
   input logic            samp1_stb,
   input logic            samp2_stb,
   input logic            token_out
);

   // R1: reset leaves every row line off in the next cycle
   assert_reset_off_R1: assert property (@(posedge clk)
      rst |=> (gate_en == '0 && clear_en == '0 && !token_out));

   // R5: never more than one row or one pair selected
   assert_one_row_R5: assert property (@(posedge clk) disable iff (rst)
      $countones(gate_en) <= 2);

   // R6: clear only where the gate is on
   assert_clear_in_gate_R6: assert property (@(posedge clk) disable iff (rst)
      (clear_en & ~gate_en) == '0);

   // R6: row selection unchanged in the cycle after a clear
   assert_clear_no_switch_R6: assert property (@(posedge clk) disable iff (rst)
      (clear_en != '0) |=> (gate_en == $past(gate_en)));

   // R3: strobes are exclusive and only while a row is selected
   assert_strobe_in_row_R3: assert property (@(posedge clk) disable iff (rst)
      (samp1_stb || samp2_stb) |-> (gate_en != '0 && !(samp1_stb && samp2_stb)));

   // R9: hand-off lasts one cycle with the rows off
   assert_token_single_R9: assert property (@(posedge clk) disable iff (rst)
      token_out |=> !token_out);

   assert_token_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      token_out |-> (gate_en == '0 && !samp1_stb && !samp2_stb));

endmodule

bind row_steer_seq rsq_checker #(.N_CH(N_CH)) u_rsq_checker (
   .clk       (clk),
   .rst       (rst),
   .gate_en   (gate_en),
   .clear_en  (clear_en),
   .samp1_stb (samp1_stb),
   .samp2_stb (samp2_stb),
   .token_out (token_out)
);

// File: tb/row_steer_seq_tb_top.sv
module row_steer_seq_tb_top;

   localparam int N = 64;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         run = 1'b0;
   logic         dbl_mode = 1'b0;
   logic         token_in = 1'b0;
   logic [W-1:0] t_settle = 8'd1, t_samp1 = 8'd1, t_clear = 8'd1, t_samp2 = 8'd1;
   logic [N-1:0] gate_en, clear_en;
   logic         samp1_stb, samp2_stb, token_out;

   always #4 clk = ~clk;

   row_steer_seq #(.N_CH(N), .CNT_W(W)) dut_i (
      .clk(clk), .rst(rst), .run(run), .dbl_mode(dbl_mode), .token_in(token_in),
      .t_settle(t_settle), .t_samp1(t_samp1), .t_clear(t_clear), .t_samp2(t_samp2),
      .gate_en(gate_en), .clear_en(clear_en), .samp1_stb(samp1_stb),
      .samp2_stb(samp2_stb), .token_out(token_out)
   );

   int checks = 0;
   int fails  = 0;
   bit cmp_en = 1'b0;
   bit done   = 1'b0;
   int cyc    = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Behavioural reference: busy flag, phase index 0..3, count, step.
   bit m_busy = 0, m_tok = 0, m_dbl = 0;
   int m_phase = 0, m_cnt = 0, m_step = 0;

   function automatic int eff(input int d);
      return (d == 0) ? 1 : d;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         m_busy = 0; m_tok = 0; m_step = 0;
      end else if (m_tok) begin
         m_tok = 0;
      end else if (!m_busy) begin
         if (token_in && run) begin
            m_busy = 1; m_phase = 0; m_cnt = 0; m_step = 0; m_dbl = dbl_mode;
         end
      end else begin
         int d;
         int last;
         case (m_phase)
            0: d = eff(int'(t_settle));
            1: d = eff(int'(t_samp1));
            2: d = eff(int'(t_clear));
            default: d = eff(int'(t_samp2));
         endcase
         last = m_dbl ? (N / 2 - 1) : (N - 1);
         if (m_cnt + 1 < d) m_cnt++;
         else begin
            m_cnt = 0;
            if (m_phase < 3) m_phase++;
            else begin
               m_phase = 0;
               if (m_step == last) begin m_busy = 0; m_tok = 1; end
               else m_step++;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         logic [N-1:0] eg, ec;
         eg = '0;
         if (m_busy) begin
            if (m_dbl) begin eg[2*m_step] = 1'b1; eg[2*m_step+1] = 1'b1; end
            else eg[m_step] = 1'b1;
         end
         ec = (m_busy && m_phase == 2) ? eg : '0;
         chk("R5 gate vector", gate_en, eg);
         chk("R6 clear vector", clear_en, ec);
         chk("R3 sample1 strobe", 64'(samp1_stb), 64'(m_busy && m_phase == 1));
         chk("R3 sample2 strobe", 64'(samp2_stb), 64'(m_busy && m_phase == 3));
         chk("R9 token out", 64'(token_out), 64'(m_tok));
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // Runs a pass; counts gate-on cycles until the token out appears.
   task automatic run_pass(input int exp_gate, input logic [63:0] first_gate,
                           input string req, input bit poke, input bit flip);
      int n = 0;
      int g = 0;
      @(negedge clk); token_in = 1'b1;
      @(negedge clk); token_in = 1'b0;
      chk({req, " first selection"}, gate_en, first_gate);
      while (!token_out && g < 20000) begin
         if (gate_en != '0) n++;
         if (poke && g == 5)  token_in = 1'b1;   // R11: token while busy
         if (poke && g == 6)  token_in = 1'b0;
         if (flip && g == 3)  dbl_mode = ~dbl_mode; // R10: mode change mid-pass
         g++;
         @(negedge clk);
      end
      chk({req, " gate-on cycles"}, n, exp_gate);
      @(negedge clk);
      chk("R9 idle after hand-off", {gate_en[N-2:0], token_out}, '0);
   endtask

   initial begin
      run = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 reset gate", gate_en, '0);
      chk("R1 reset clear", clear_en, '0);
      chk("R1 reset strobes/token", {samp1_stb, samp2_stb, token_out}, '0);
      rst = 1'b0;
      cmp_en = 1'b1;

      // R2: token ignored while disabled
      run = 1'b0;
      @(negedge clk); token_in = 1'b1;
      @(negedge clk); token_in = 1'b0;
      for (int i = 0; i < 8; i++) begin
         chk("R2 disabled token", gate_en, '0);
         @(negedge clk);
      end
      run = 1'b1;

      // R7/R11: single-row pass, lengths 1,2,3,1 -> 7 cycles per row
      t_settle = 8'd1; t_samp1 = 8'd2; t_clear = 8'd3; t_samp2 = 8'd1; dbl_mode = 1'b0;
      run_pass(N * 7, 64'h1, "R7 single pass", 1'b1, 1'b0);
      chk("R11 busy token ignored", {gate_en[N-2:0], token_out}, '0);

      // R8/R10: double-row pass with mode flipped mid-pass, 2,1,1,2 -> 6 per pair
      t_settle = 8'd2; t_samp1 = 8'd1; t_clear = 8'd1; t_samp2 = 8'd2; dbl_mode = 1'b1;
      run_pass((N / 2) * 6, 64'h3, "R8 R10 double pass", 1'b0, 1'b1);

      // R4: zero lengths act as one cycle each
      t_settle = 8'd0; t_samp1 = 8'd0; t_clear = 8'd0; t_samp2 = 8'd0; dbl_mode = 1'b0;
      run_pass(N * 4, 64'h1, "R4 zero lengths", 1'b0, 1'b0);

      // R1: reset mid-pass, then a fresh pass starts at channel 0
      t_settle = 8'd3; t_samp1 = 8'd1; t_clear = 8'd2; t_samp2 = 8'd1;
      @(negedge clk); token_in = 1'b1;
      @(negedge clk); token_in = 1'b0;
      repeat (20) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 mid-pass reset gate", gate_en, '0);
      chk("R1 mid-pass reset clear", clear_en, '0);
      repeat (3) @(negedge clk);
      chk("R1 stays idle after reset", gate_en, '0);
      run_pass(N * 7, 64'h1, "R1 R7 restart pass", 1'b0, 1'b0);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule